// File: doc/BRIEF.md
# Remapping Tag Buffer

The block is a small associative store that sits in front of an in-package DRAM cache. It holds recent changes to where data blocks live. Cores can therefore keep stale location hints in their translation tables without a broadcast on every move. Every outgoing memory request first presents its address tag. If a valid entry matches, the location recorded in the buffer replaces the 3-bit hint that came with the request. On a miss, the hint passes through unchanged. The resolved location is encoded as follows: bit 2 is the present flag, and bits 1:0 are the way among the four blocks that share a hash index. The present flag also decides whether the request goes to the DRAM cache or to main memory.

Cache fills and evictions write entries through an insert port. An insert for a tag already held rewrites that entry in place. An insert for a new tag takes the lowest-numbered free slot. Once every slot is valid, the buffer raises a flush request so that all cores can rewrite their tables, and it stalls further inserts. The acknowledge clears every entry in one cycle, and filling then starts again. Total storage is ENTRIES × (TAG_W + 4) bits and is meant to stay within about 5 KB.

Top module: `remap_tag_buffer`

## Requirements
- R1: A lookup whose tag matches a valid entry raises `lk_hit` in the same cycle and returns that entry's stored 3-bit location on `lk_loc`.
- R2: A lookup whose tag matches no valid entry drives `lk_hit` low and returns `lk_hint` unchanged on `lk_loc`.
- R3: Location encoding is bit 2 = present in the DRAM cache and bits 1:0 = way. `lk_to_dram` equals bit 2 of the resolved location, so a present bit of 0 routes the request to main memory.
- R4: An accepted insert whose tag is already held overwrites that entry's location and allocates no new entry. Only distinct tags count towards capacity.
- R5: `full` and `flush_req` rise in the cycle after the insert that makes ENTRIES distinct tags valid, and not earlier.
- R6: While `full` is high, `ins_ready` is low, inserts change no entry, and lookups are still answered from the current contents.
- R7: `flush_ack` sampled while `full` is high clears every entry by the next cycle: `full` drops, and all earlier tags miss. `flush_ack` while not full has no effect.
- R8: After reset the buffer is empty, `full` and `flush_req` are low, and `ins_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_tag | input | TAG_W | Tag of the request being looked up |
| lk_hint | input | 3 | Location hint carried by the request |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_loc | output | 3 | Resolved location {present, way} |
| lk_to_dram | output | 1 | Request is routed to the DRAM cache (1) or main memory (0) |
| ins_valid | input | 1 | Insert/update request |
| ins_tag | input | TAG_W | Tag to record |
| ins_loc | input | 3 | New location {present, way} |
| ins_ready | output | 1 | Insert accepted this cycle when high |
| full | output | 1 | Every slot holds a valid entry |
| flush_req | output | 1 | Request for a global translation-table update |
| flush_ack | input | 1 | Table update done; clear the buffer |

## Verification
A corrupted entry shows at the ports at once: the next lookup of that tag returns the wrong location or the wrong routing bit in the same cycle. A duplicated or lost allocation cannot be seen on a single lookup. It appears only as `full` rising one insert early or late. For that reason the bench counts distinct tags in its own model and compares `full` after every insert. A clear that is missed or only partial shows up as stale hits on the first lookups after the acknowledge.

// File: rtl/rtb_pkg.sv
// Package: shared types for the remapping tag buffer.
// Assumes a 3-bit location: present flag over a 2-bit way index.
package rtb_pkg;
    localparam int LOC_W = 3;

    typedef struct packed {
        logic       present;
        logic [1:0] way;
    } loc_t;
endpackage

// File: rtl/rtb_free_pick.sv
// Module: picks the lowest-numbered invalid slot.
// Assumes the valid vector is registered; the output is purely combinational.
module rtb_free_pick #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] valid,
    output logic [IDX_W-1:0]   free_idx,
    output logic               any_free
);
    // Priority scan from the top so the lowest free index wins.
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtb_entry_array.sv
// Module: entry storage with two parallel tag comparators.
// One comparator serves lookups and the other finds an existing slot for inserts.
// Assumes tags are unique among valid entries, which the top guarantees.
module rtb_entry_array
    import rtb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 24,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TAG_W-1:0]   lk_tag,
    input  logic [TAG_W-1:0]   ins_tag,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  loc_t               wr_loc,
    input  logic               clear,
    output logic [ENTRIES-1:0] valid_o,
    output logic               lk_hit,
    output loc_t               lk_loc,
    output logic               ins_hit,
    output logic [IDX_W-1:0]   ins_idx
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    loc_t               loc_q [ENTRIES];
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] ins_match;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_slot
            // Per-slot comparators against both request tags.
            assign lk_match[g]  = valid_q[g] && (tag_q[g] == lk_tag);
            assign ins_match[g] = valid_q[g] && (tag_q[g] == ins_tag);

            // Slot state: cleared on reset or flush, written when selected.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    valid_q[g] <= 1'b0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    valid_q[g] <= 1'b1;
                end
            end

            // Payload registers need no reset; they are qualified by valid.
            always_ff @(posedge clk) begin
                if (wr_en && !clear && (wr_idx == IDX_W'(g))) begin
                    tag_q[g] <= ins_tag;
                    loc_q[g] <= wr_loc;
                end
            end
        end
    endgenerate

    // One-hot OR-mux of the matching location and the matching index.
    always_comb begin
        lk_loc  = '0;
        ins_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i])  lk_loc  = lk_loc | loc_q[i];
            if (ins_match[i]) ins_idx = ins_idx | IDX_W'(i);
        end
    end

    assign lk_hit  = |lk_match;
    assign ins_hit = |ins_match;
    assign valid_o = valid_q;

    AST_ONEHOT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match)); // R4
    AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> valid_q[$past(wr_idx)]); // R1
endmodule

// File: rtl/remap_tag_buffer.sv
// Module: top of the remapping tag buffer.
// Lookups resolve combinationally; inserts update in place or allocate.
// A full buffer requests a global table update and clears itself on the acknowledge.
// Assumes ENTRIES * (TAG_W + 4) bits stays within the ~5 KB budget.
module remap_tag_buffer
    import rtb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 24,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic [2:0]       lk_hint,
    output logic             lk_hit,
    output logic [2:0]       lk_loc,
    output logic             lk_to_dram,
    input  logic             ins_valid,
    input  logic [TAG_W-1:0] ins_tag,
    input  logic [2:0]       ins_loc,
    output logic             ins_ready,
    output logic             full,
    output logic             flush_req,
    input  logic             flush_ack
);
    logic [ENTRIES-1:0] valid;
    logic               arr_hit;
    loc_t               arr_loc;
    logic               ins_hit;
    logic [IDX_W-1:0]   ins_idx;
    logic [IDX_W-1:0]   free_idx;
    logic               any_free;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    logic               clear;
    loc_t               resolved;

    rtb_entry_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_tag  (lk_tag),
        .ins_tag (ins_tag),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_loc  (loc_t'(ins_loc)),
        .clear   (clear),
        .valid_o (valid),
        .lk_hit  (arr_hit),
        .lk_loc  (arr_loc),
        .ins_hit (ins_hit),
        .ins_idx (ins_idx)
    );

    rtb_free_pick #(.ENTRIES(ENTRIES)) u_pick (
        .valid    (valid),
        .free_idx (free_idx),
        .any_free (any_free)
    );

    // Capacity and flush handshake: a full buffer stalls inserts until the acknowledge.
    always_comb begin
        full      = &valid;
        flush_req = full;
        ins_ready = !full;
        clear     = full && flush_ack;
    end

    // Insert steering: rewrite a matching slot in place, else take a free one.
    always_comb begin
        wr_idx = ins_hit ? ins_idx : free_idx;
        wr_en  = ins_valid && ins_ready && (ins_hit || any_free);
    end

    // Lookup resolution: a buffer hit overrides the request's hint.
    always_comb begin
        resolved   = arr_hit ? arr_loc : loc_t'(lk_hint);
        lk_hit     = arr_hit;
        lk_loc     = resolved;
        lk_to_dram = resolved.present;
    end

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !flush_ack) |=> full); // R6
    AST_CLEAR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (full && flush_ack) |=> (valid == '0)); // R7
    AST_UPDATE_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ins_hit) |=> ($countones(valid) == $countones($past(valid)))); // R4
    AST_NEW_TAG_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ins_hit) |=> ($countones(valid) == $countones($past(valid)) + 1)); // R5
endmodule

// File: tb/remap_tag_buffer_test.sv
// Bench: random inserts from a small tag pool, plus directed corner cases.
// All results are compared against a bench model of the stored tag/location set.
module remap_tag_buffer_test;
    localparam int ENTRIES = 16;
    localparam int TAG_W   = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [TAG_W-1:0] lk_tag = '0;
    logic [2:0]       lk_hint = '0;
    logic             lk_hit;
    logic [2:0]       lk_loc;
    logic             lk_to_dram;
    logic             ins_valid = 1'b0;
    logic [TAG_W-1:0] ins_tag = '0;
    logic [2:0]       ins_loc = '0;
    logic             ins_ready;
    logic             full;
    logic             flush_req;
    logic             flush_ack = 1'b0;

    int checks = 0;
    int failures = 0;

    // Model: set of distinct tags with their latest locations.
    logic [TAG_W-1:0] m_tag [ENTRIES];
    logic [2:0]       m_loc [ENTRIES];
    int               m_cnt = 0;

    remap_tag_buffer #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) uut (
        .clk(clk), .rst_n(rst_n), .lk_tag(lk_tag), .lk_hint(lk_hint),
        .lk_hit(lk_hit), .lk_loc(lk_loc), .lk_to_dram(lk_to_dram),
        .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_loc(ins_loc),
        .ins_ready(ins_ready), .full(full), .flush_req(flush_req),
        .flush_ack(flush_ack)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int m_find(input logic [TAG_W-1:0] t);
        for (int i = 0; i < m_cnt; i++) if (m_tag[i] == t) return i;
        return -1;
    endfunction

    // Lookup checked against the model (R1, R2, R3).
    task automatic lookup_chk(input logic [TAG_W-1:0] t, input logic [2:0] h);
        int idx;
        logic [2:0] exp_loc;
        @(negedge clk);
        lk_tag = t;
        lk_hint = h;
        #1;
        idx = m_find(t);
        exp_loc = (idx >= 0) ? m_loc[idx] : h;
        if (idx >= 0) check(lk_loc == exp_loc, "R1 hit loc", lk_loc, exp_loc);
        else          check(lk_loc == exp_loc, "R2 miss hint", lk_loc, exp_loc);
        check(lk_hit == (idx >= 0), "R1/R2 hit flag", lk_hit, (idx >= 0));
        check(lk_to_dram == exp_loc[2], "R3 routing", lk_to_dram, exp_loc[2]);
    endtask

    // One insert cycle; the model follows only if the insert was accepted.
    task automatic insert(input logic [TAG_W-1:0] t, input logic [2:0] l);
        bit acc;
        int idx;
        @(negedge clk);
        ins_valid = 1'b1;
        ins_tag = t;
        ins_loc = l;
        #1;
        acc = ins_ready;
        check(ins_ready == (m_cnt != ENTRIES), "R6 ready", ins_ready, (m_cnt != ENTRIES));
        @(posedge clk);
        #1;
        ins_valid = 1'b0;
        if (acc) begin
            idx = m_find(t);
            if (idx >= 0) m_loc[idx] = l;
            else begin
                m_tag[m_cnt] = t;
                m_loc[m_cnt] = l;
                m_cnt++;
            end
        end
        check(full == (m_cnt == ENTRIES), "R5 full", full, (m_cnt == ENTRIES));
        check(flush_req == (m_cnt == ENTRIES), "R5 flush_req", flush_req, (m_cnt == ENTRIES));
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        flush_ack = 1'b1;
        @(posedge clk);
        #1;
        flush_ack = 1'b0;
        if (m_cnt == ENTRIES) m_cnt = 0;
        check(full == 1'b0, "R7 full after ack", full, 0);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R8: reset state.
        check(full == 0, "R8 full", full, 0);
        check(flush_req == 0, "R8 flush_req", flush_req, 0);
        check(ins_ready == 1, "R8 ready", ins_ready, 1);
        lookup_chk(24'h000011, 3'b010);

        // R4: repeated tag rewrites in place and does not consume capacity.
        insert(24'h0000AA, 3'b101);
        insert(24'h0000AA, 3'b110);
        lookup_chk(24'h0000AA, 3'b000);
        check(m_cnt == 1, "R4 model count", m_cnt, 1);
        // R7: acknowledge while not full is ignored.
        @(negedge clk);
        flush_ack = 1'b1;
        @(posedge clk);
        #1;
        flush_ack = 1'b0;
        lookup_chk(24'h0000AA, 3'b001);

        // Random rounds: fill from a small pool, so repeats are common.
        for (int round = 0; round < 6; round++) begin
            while (m_cnt != ENTRIES) begin
                insert(24'($urandom_range(0, 40)), 3'($urandom));
                lookup_chk(24'($urandom_range(0, 40)), 3'($urandom));
            end
            // R6: stalled insert of a new tag changes nothing; lookups still work.
            insert(24'h00FFFF, 3'b111);
            lookup_chk(24'h00FFFF, 3'b000);
            lookup_chk(m_tag[round % ENTRIES], 3'b000);
            check(full == 1, "R6 still full", full, 1);
            begin
                logic [TAG_W-1:0] old_t;
                old_t = m_tag[0];
                pulse_ack();
                // R7: every previous tag now misses.
                lookup_chk(old_t, 3'b011);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule